// File: doc/BRIEF.md
# Configuration Register Command Decoder

This block receives configuration commands from a host control endpoint as a stream of plain bytes, one byte per cycle in which `cmd_valid` is high. Commands have a fixed length and begin with an opcode. A write command carries a register address and one data byte, and the block applies it to a small internal register file. A read command carries a register address, and the block answers it with exactly one byte on a separate response stream.

The register file holds the 16-bit probe enable mask, split over two byte registers, together with the sample clock divisor code and the base clock select. These registers drive the sample packer and the sample clock divider directly. Typical mask values are 0x0007, 0x003F, 0x01FF and 0xFFFF, which select 3, 6, 9 and 16 probes. Any scrambling on the link is removed before the bytes reach this block.

Top module: `cfgdec_top`

## Requirements
- R1: During and after synchronous reset, `probe_mask`, `div_code` and `base_sel` are 0 and `rsp_valid` is low.
- R2: A write is the byte sequence 0x80, 0x01, address, data. The addressed register takes the data on the clock edge that accepts the data byte. No output changes before that edge.
- R3: A read is the byte sequence 0x81, 0x01, address. In the cycle after the edge that accepts the address byte, `rsp_valid` is high for exactly one cycle and `rsp_byte` holds the current register value.
- R4: Address 0x02 holds bits 7:0 of `probe_mask` and address 0x03 holds bits 15:8.
- R5: Address 0x04 holds `div_code` and address 0x0A holds `base_sel`.
- R6: A write to any other address changes no output. A read of any other address returns 0x00.
- R7: A leading byte that is neither 0x80 nor 0x81 is discarded and has no effect.
- R8: If the second byte of a command is not 0x01, the command is dropped and that byte is examined again as a possible first byte of a new command.
- R9: Bytes are counted only in cycles where `cmd_valid` is high. Idle cycles between the bytes of a command do not disturb it.
- R10: In a cycle with `cmd_valid` low, no register output changes and no response is produced on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte |
| rsp_valid | output | 1 | One-cycle pulse that marks a response byte |
| rsp_byte | output | 8 | Response byte of a read |
| probe_mask | output | 16 | Probe enable mask |
| div_code | output | 8 | Sample clock divisor code |
| base_sel | output | 8 | Base clock select |

## Verification
The hardest case to reach from the ports is a command that breaks off halfway: a write opcode followed by a read opcode in the position of the sub-code. The parser must then drop the write and carry on as a read of the following address. The stimulus sends exactly this interleaving and expects one response for it from the scoreboard. It also spreads command bytes across idle cycles and checks, before the final byte arrives, that no register has moved yet.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WRITE    = 8'h80;
    localparam logic [BYTE_W-1:0] OP_READ     = 8'h81;
    localparam logic [BYTE_W-1:0] SUB_CODE    = 8'h01;
    localparam logic [BYTE_W-1:0] ADR_MASK_LO = 8'h02;
    localparam logic [BYTE_W-1:0] ADR_DIV     = 8'h04;
    localparam logic [BYTE_W-1:0] ADR_BASE    = 8'h0A;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_W_SUB,
        PS_W_ADR,
        PS_W_DAT,
        PS_R_SUB,
        PS_R_ADR
    } pstate_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } regop_t;

    function automatic pstate_e lead_state(logic [BYTE_W-1:0] b);
        case (b)
            OP_WRITE: return PS_W_SUB;
            OP_READ:  return PS_R_SUB;
            default:  return PS_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/cfgdec_parser.sv
module cfgdec_parser
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output regop_t            op
);

    pstate_e           state_q, state_d;
    logic [BYTE_W-1:0] addr_q, addr_d;

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        op      = '0;
        if (in_valid) begin
            case (state_q)
                PS_IDLE:  state_d = lead_state(in_byte);
                PS_W_SUB: state_d = (in_byte == SUB_CODE) ? PS_W_ADR : lead_state(in_byte);
                PS_W_ADR: begin
                    addr_d  = in_byte;
                    state_d = PS_W_DAT;
                end
                PS_W_DAT: begin
                    op.wr   = 1'b1;
                    op.addr = addr_q;
                    op.data = in_byte;
                    state_d = PS_IDLE;
                end
                PS_R_SUB: state_d = (in_byte == SUB_CODE) ? PS_R_ADR : lead_state(in_byte);
                PS_R_ADR: begin
                    op.rd   = 1'b1;
                    op.addr = in_byte;
                    state_d = PS_IDLE;
                end
                default:  state_d = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

endmodule

// File: rtl/cfgdec_regfile.sv
module cfgdec_regfile
    import cfgdec_pkg::*;
#(
    parameter int MASK_BYTES = 2,
    localparam int MASK_W    = MASK_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  regop_t            op,
    output logic [MASK_W-1:0] mask,
    output logic [BYTE_W-1:0] div_code,
    output logic [BYTE_W-1:0] base_sel,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mask_q [MASK_BYTES];

    for (genvar g = 0; g < MASK_BYTES; g++) begin : g_mask
        localparam logic [BYTE_W-1:0] MY_ADR = ADR_MASK_LO + BYTE_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= '0;
            end else if (op.wr && op.addr == MY_ADR) begin
                mask_q[g] <= op.data;
            end
        end
        assign mask[g*BYTE_W +: BYTE_W] = mask_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_code <= '0;
            base_sel <= '0;
        end else if (op.wr) begin
            if (op.addr == ADR_DIV)  div_code <= op.data;
            if (op.addr == ADR_BASE) base_sel <= op.data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (op.addr == ADR_DIV)  rd_data = div_code;
        if (op.addr == ADR_BASE) rd_data = base_sel;
        for (int i = 0; i < MASK_BYTES; i++) begin
            if (op.addr == ADR_MASK_LO + BYTE_W'(i)) rd_data = mask_q[i];
        end
    end

endmodule

// File: rtl/cfgdec_rsp.sv
module cfgdec_rsp
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  regop_t            op,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= op.rd;
            if (op.rd) rsp_byte <= rd_data;
        end
    end

endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
#(
    parameter int MASK_BYTES = 2,
    localparam int MASK_W    = MASK_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte,
    output logic [MASK_W-1:0] probe_mask,
    output logic [BYTE_W-1:0] div_code,
    output logic [BYTE_W-1:0] base_sel
);

    regop_t            op;
    logic [BYTE_W-1:0] rd_data;

    cfgdec_parser u_parser (
        .clk      (clk),
        .rst      (rst),
        .in_valid (cmd_valid),
        .in_byte  (cmd_byte),
        .op       (op)
    );

    cfgdec_regfile #(.MASK_BYTES(MASK_BYTES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .mask     (probe_mask),
        .div_code (div_code),
        .base_sel (base_sel),
        .rd_data  (rd_data)
    );

    cfgdec_rsp u_rsp (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .rd_data   (rd_data),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte)
    );

endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker #(
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              rsp_valid,
    input logic [MASK_W-1:0] probe_mask,
    input logic [7:0]        div_code,
    input logic [7:0]        base_sel
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (probe_mask == '0 && div_code == '0 && base_sel == '0 && !rsp_valid)); // R1

    AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3

    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid); // R10

    AST_IDLE_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(probe_mask)); // R10

    AST_IDLE_CLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(div_code) && $stable(base_sel))); // R10

endmodule

bind cfgdec_top cfgdec_checker #(.MASK_W(MASK_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .rsp_valid  (rsp_valid),
    .probe_mask (probe_mask),
    .div_code   (div_code),
    .base_sel   (base_sel)
);

// File: tb/cfgdec_top_tb_top.sv
module cfgdec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_byte;
    logic [15:0] probe_mask;
    logic [7:0]  div_code;
    logic [7:0]  base_sel;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         summary_done = 1'b0;

    always #5 clk = ~clk;

    cfgdec_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .rsp_valid  (rsp_valid),
        .rsp_byte   (rsp_byte),
        .probe_mask (probe_mask),
        .div_code   (div_code),
        .base_sel   (base_sel)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic put(logic [7:0] b, int gap = 0);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_byte  = 8'hEE;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        put(8'h80); put(8'h01); put(a); put(d);
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        put(8'h81); put(8'h01); put(a);
        @(negedge clk);
    endtask

    // Monitor: pops one expected byte for every response pulse.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R3_unexpected_rsp", 32'(rsp_byte), 32'hFFFF_FFFF);
            end else begin
                check(tag_q.pop_front(), 32'(rsp_byte), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1_mask", 32'(probe_mask), 0);
        check("R1_div", 32'(div_code), 0);
        check("R1_base", 32'(base_sel), 0);
        check("R1_rsp", 32'(rsp_valid), 0);
        rst = 1'b0;
        rd(8'h02, 8'h00, "R1_read_mask_lo");

        // R2/R4 mask values for 3, 6, 9, 16 probes
        wr(8'h02, 8'h07); wr(8'h03, 8'h00);
        check("R4_mask_3", 32'(probe_mask), 32'h0007);
        wr(8'h02, 8'h3F);
        check("R4_mask_6", 32'(probe_mask), 32'h003F);
        wr(8'h02, 8'hFF); wr(8'h03, 8'h01);
        check("R4_mask_9", 32'(probe_mask), 32'h01FF);
        wr(8'h03, 8'hFF);
        check("R4_mask_16", 32'(probe_mask), 32'hFFFF);
        rd(8'h03, 8'hFF, "R3_read_mask_hi");

        // R5 clock registers
        wr(8'h04, 8'hC7); wr(8'h0A, 8'h01);
        check("R5_div", 32'(div_code), 32'hC7);
        check("R5_base", 32'(base_sel), 32'h01);
        rd(8'h04, 8'hC7, "R5_read_div");
        rd(8'h0A, 8'h01, "R5_read_base");

        // R6 unimplemented address
        wr(8'h05, 8'h55); wr(8'h00, 8'hAA);
        check("R6_mask", 32'(probe_mask), 32'hFFFF);
        check("R6_div", 32'(div_code), 32'hC7);
        check("R6_base", 32'(base_sel), 32'h01);
        rd(8'h05, 8'h00, "R6_read_unimpl");

        // R7 junk leading bytes: 0x12 dropped, then 0x01, 0x02, 0x33 all dropped
        put(8'h12); put(8'h01); put(8'h02); put(8'h33);
        check("R7_mask", 32'(probe_mask), 32'hFFFF);
        rd(8'h02, 8'hFF, "R7_read_after_junk");

        // R8 write broken by read opcode, which becomes a read of 0x04
        exp_q.push_back(8'hC7);
        tag_q.push_back("R8_resync_read");
        put(8'h80); put(8'h81); put(8'h01); put(8'h04);
        @(negedge clk);
        check("R8_div_untouched", 32'(div_code), 32'hC7);
        // R8 bad sub-code aborts write: 0x80 0x04 0x02 0x00 must not write
        put(8'h80); put(8'h04); put(8'h02); put(8'h00);
        check("R8_abort_mask", 32'(probe_mask), 32'hFFFF);

        // R9 gaps between bytes; R2 no change before data byte
        put(8'h80, 3); put(8'h01, 2); put(8'h04, 4);
        check("R2_before_data", 32'(div_code), 32'hC7);
        put(8'h09, 2);
        check("R9_gapped_write", 32'(div_code), 32'h09);
        put(8'h81, 2); put(8'h01, 1);
        exp_q.push_back(8'h09);
        tag_q.push_back("R9_gapped_read");
        put(8'h04);
        @(negedge clk);

        // R1 reset again clears everything
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1_mask_rst2", 32'(probe_mask), 0);
        check("R1_div_rst2", 32'(div_code), 0);

        repeat (3) @(negedge clk);
        check("R3_all_responses_seen", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule